// File: doc/BRIEF.md
# Serial Configuration Slave for a Clock Generator

This block is a two-wire serial slave that holds the six 8-bit configuration bytes of a system clock generator. A host writes them with a block transfer: after the device address comes a command byte and a count byte, and the slave acknowledges both and discards their values. The data bytes follow, and the slave always loads them into configuration byte 0 upward. The host can end the transfer with a STOP after any whole byte. A block read returns a count byte equal to six, followed by the six configuration bytes in ascending order.

The bus lines are sampled by a fast system clock through synchronizers, so the block lives entirely in one clock domain. SDA is driven open-drain: the block only ever requests that the line be pulled low. Four frequency-select strap levels, latched elsewhere at power-on, appear inverted in fixed read-only bit positions. Reserved bits always read as one. The six configuration bytes are presented on output ports for the synthesizer logic that consumes them.

Top module: `i2c_cfg_slave`

## Requirements
- R1: The slave acknowledges a first byte of D2h (7-bit address 69h, write) or D3h (read). Any other address byte is not acknowledged, and the transfer that follows it changes no configuration byte.
- R2: In a write, the two bytes after the address (command, then count) are acknowledged, and their values reach no configuration byte.
- R3: In a write, the third byte after the address loads configuration byte 0, the next one byte 1, and so on up to byte 5, each byte sent MSB first. After a STOP that follows any whole byte, the loaded bytes keep their values and the others are unchanged.
- R4: A data byte interrupted by a STOP before its eighth bit changes no configuration byte.
- R5: In a write, a data byte after the sixth is not acknowledged and changes no configuration byte.
- R6: After reset, byte 0 reads 00h. In bytes 1 to 5, every writable and reserved bit reads 1.
- R7: The writable bits are these: byte 0 all bits, byte 1 bits 3,1,0 (mask 0Bh), byte 2 mask 5Fh, byte 3 mask 37h, byte 4 none, byte 5 mask 13h. Strap inputs fsStrap[k] hold select line k. The read-only bits are byte 1 bit 7 = ~fsStrap[2], byte 3 bit 6 = ~fsStrap[0], byte 4 bit 3 = ~fsStrap[1] and byte 4 bit 1 = ~fsStrap[3]. They follow the straps whatever is written.
- R8: Reserved bits (byte 1 bits 6,5,4,2; byte 2 bits 7,5; byte 3 bits 7,3; byte 4 bits 7,6,5,4,2,0; byte 5 bits 7,6,5,3,2) read 1 regardless of writes.
- R9: In a read, the slave sends a count byte of 06h, then bytes 0 to 5, each MSB first. It moves to the next byte each time the host acknowledges.
- R10: When the host does not acknowledge a read byte, the slave stops driving SDA until the next START.
- R11: The slave changes its SDA drive only while SCL is low, and it does not drive SDA while the bus is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rstN | input | 1 | Asynchronous active-low reset |
| sclIn | input | 1 | Serial clock line level |
| sdaIn | input | 1 | Serial data line level |
| sdaDrvLow | output | 1 | 1 = pull SDA low, 0 = release |
| fsStrap | input | 4 | Latched frequency-select strap levels, bit k = select line k |
| cfgByte0 | output | 8 | Configuration byte 0 (function and frequency control) |
| cfgByte1 | output | 8 | Configuration byte 1 |
| cfgByte2 | output | 8 | Configuration byte 2 |
| cfgByte3 | output | 8 | Configuration byte 3 |
| cfgByte4 | output | 8 | Configuration byte 4 |
| cfgByte5 | output | 8 | Configuration byte 5 |

## Verification
The bench stops a transfer halfway through a data byte. A slave that commits on a partial shift would corrupt the next byte. It also sends a seventh data byte, which a slave without a byte limit would acknowledge or wrap into byte 0. It writes all ones and all zeros across the reserved and strap bit positions and then moves the straps, which exposes a write mask that is wrong or misplaced. A read checks the count byte and the byte order, and a host NACK followed by extra clocks shows whether the slave keeps driving the line after it has been told to stop.

// File: rtl/i2c_cfg_pkg.sv
package i2c_cfg_pkg;

  localparam int NUM_REGS = 6;
  localparam int IDX_W    = 4;
  localparam int SEL_W    = 3;

  typedef struct packed {
    logic             shiftIn;
    logic             commit;
    logic [SEL_W-1:0] regSel;
    logic             loadTx;
    logic             shiftOut;
    logic [IDX_W-1:0] txSel;
  } cfg_strobe_t;

  typedef enum logic [2:0] {
    S_IDLE, S_RX, S_GOT, S_ACK_WAIT, S_ACK, S_TX, S_HOST_ACK
  } slv_state_t;

  function automatic logic [7:0] writeMask(int idx);
    case (idx)
      0:       return 8'hFF;
      1:       return 8'h0B;
      2:       return 8'h5F;
      3:       return 8'h37;
      5:       return 8'h13;
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic [7:0] resetValue(int idx);
    return (idx == 0) ? 8'h00 : 8'hFF;
  endfunction

endpackage

// File: rtl/i2c_cfg_ctrl.sv
module i2c_cfg_ctrl
  import i2c_cfg_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR    = 7'h69,
  parameter int         SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        sclIn,
  input  logic        sdaIn,
  input  logic [7:0]  rxByte,
  output logic        sdaS,
  output cfg_strobe_t strobe,
  output logic        ackLow,
  output logic        txActive
);

  localparam int LAST_BIT  = 7;
  localparam int FIRST_REG = 2;
  localparam int LAST_WR   = FIRST_REG + NUM_REGS - 1;

  logic [SYNC_STAGES-1:0] sclPipe, sdaPipe;
  logic sclS, sclD, sdaD;
  logic sclRise, sclFall, startCond, stopCond;

  slv_state_t       state;
  logic [2:0]       bitCnt;
  logic [IDX_W-1:0] byteIdx;
  logic [IDX_W-1:0] regIdxW;
  logic addrPhase, isRead, ackPend, hostAck;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclPipe <= '1;
      sdaPipe <= '1;
      sclD    <= 1'b1;
      sdaD    <= 1'b1;
    end else begin
      sclPipe <= {sclPipe[SYNC_STAGES-2:0], sclIn};
      sdaPipe <= {sdaPipe[SYNC_STAGES-2:0], sdaIn};
      sclD    <= sclS;
      sdaD    <= sdaS;
    end
  end

  assign sclS      = sclPipe[SYNC_STAGES-1];
  assign sdaS      = sdaPipe[SYNC_STAGES-1];
  assign sclRise   = sclS & ~sclD;
  assign sclFall   = ~sclS & sclD;
  assign startCond = sclS & sclD & ~sdaS & sdaD;
  assign stopCond  = sclS & sclD & sdaS & ~sdaD;
  assign regIdxW   = byteIdx - IDX_W'(FIRST_REG);

  always_comb begin
    strobe          = '0;
    strobe.shiftIn  = (state == S_RX) && sclRise;
    strobe.commit   = (state == S_GOT) && !addrPhase && !isRead &&
                      (byteIdx >= IDX_W'(FIRST_REG)) && (byteIdx <= IDX_W'(LAST_WR));
    strobe.regSel   = regIdxW[SEL_W-1:0];
    strobe.loadTx   = sclFall && (((state == S_ACK) && isRead) ||
                                  ((state == S_HOST_ACK) && hostAck));
    strobe.shiftOut = (state == S_TX) && sclFall && (bitCnt != 3'(LAST_BIT));
    strobe.txSel    = byteIdx;
  end

  function automatic logic [IDX_W-1:0] nextIdx(logic [IDX_W-1:0] cur);
    return (cur == '1) ? cur : cur + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= S_IDLE;
      bitCnt    <= '0;
      byteIdx   <= '0;
      addrPhase <= 1'b0;
      isRead    <= 1'b0;
      ackPend   <= 1'b0;
      hostAck   <= 1'b0;
      ackLow    <= 1'b0;
      txActive  <= 1'b0;
    end else if (startCond) begin
      state     <= S_RX;
      bitCnt    <= '0;
      byteIdx   <= '0;
      addrPhase <= 1'b1;
      isRead    <= 1'b0;
      ackLow    <= 1'b0;
      txActive  <= 1'b0;
    end else if (stopCond) begin
      state    <= S_IDLE;
      ackLow   <= 1'b0;
      txActive <= 1'b0;
    end else begin
      case (state)
        S_RX: if (sclRise) begin
          if (bitCnt == 3'(LAST_BIT)) begin
            bitCnt <= '0;
            state  <= S_GOT;
          end else begin
            bitCnt <= bitCnt + 1'b1;
          end
        end
        S_GOT: begin
          if (addrPhase) begin
            addrPhase <= 1'b0;
            isRead    <= rxByte[0];
            ackPend   <= (rxByte[7:1] == DEV_ADDR);
            byteIdx   <= '0;
          end else begin
            ackPend <= (byteIdx <= IDX_W'(LAST_WR));
            byteIdx <= nextIdx(byteIdx);
          end
          state <= S_ACK_WAIT;
        end
        S_ACK_WAIT: if (sclFall) begin
          if (ackPend) begin
            ackLow <= 1'b1;
            state  <= S_ACK;
          end else begin
            state <= S_IDLE;
          end
        end
        S_ACK: if (sclFall) begin
          ackLow <= 1'b0;
          bitCnt <= '0;
          if (isRead) begin
            txActive <= 1'b1;
            byteIdx  <= nextIdx(byteIdx);
            state    <= S_TX;
          end else begin
            state <= S_RX;
          end
        end
        S_TX: if (sclFall) begin
          if (bitCnt == 3'(LAST_BIT)) begin
            txActive <= 1'b0;
            state    <= S_HOST_ACK;
          end else begin
            bitCnt <= bitCnt + 1'b1;
          end
        end
        S_HOST_ACK: begin
          if (sclRise) hostAck <= ~sdaS;
          if (sclFall) begin
            if (hostAck) begin
              txActive <= 1'b1;
              bitCnt   <= '0;
              byteIdx  <= nextIdx(byteIdx);
              state    <= S_TX;
            end else begin
              state <= S_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/i2c_cfg_datapath.sv
module i2c_cfg_datapath
  import i2c_cfg_pkg::*;
(
  input  logic                       clk,
  input  logic                       rstN,
  input  cfg_strobe_t                strobe,
  input  logic                       sdaS,
  input  logic [3:0]                 fsStrap,
  output logic [7:0]                 rxByte,
  output logic                       txBit,
  output logic [NUM_REGS-1:0][7:0]   cfgView
);

  logic [7:0] rxShift, txShift, txValue;
  logic [NUM_REGS-1:0][7:0] store;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rxShift <= '0;
    else if (strobe.shiftIn) rxShift <= {rxShift[6:0], sdaS};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_REGS; i++) store[i] <= resetValue(i);
    end else begin
      for (int i = 0; i < NUM_REGS; i++) begin
        if (strobe.commit && (strobe.regSel == SEL_W'(i)))
          store[i] <= (store[i] & ~writeMask(i)) | (rxShift & writeMask(i));
      end
    end
  end

  always_comb begin
    cfgView       = store;
    cfgView[1][7] = ~fsStrap[2];
    cfgView[3][6] = ~fsStrap[0];
    cfgView[4][3] = ~fsStrap[1];
    cfgView[4][1] = ~fsStrap[3];
  end

  always_comb begin
    txValue = 8'hFF;
    if (strobe.txSel == '0) txValue = 8'(NUM_REGS);
    for (int i = 0; i < NUM_REGS; i++) begin
      if (strobe.txSel == IDX_W'(i + 1)) txValue = cfgView[i];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) txShift <= 8'hFF;
    else if (strobe.loadTx) txShift <= txValue;
    else if (strobe.shiftOut) txShift <= {txShift[6:0], 1'b1};
  end

  assign rxByte = rxShift;
  assign txBit  = txShift[7];

endmodule

// File: rtl/i2c_cfg_slave.sv
module i2c_cfg_slave
  import i2c_cfg_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR    = 7'h69,
  parameter int         SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclIn,
  input  logic       sdaIn,
  output logic       sdaDrvLow,
  input  logic [3:0] fsStrap,
  output logic [7:0] cfgByte0,
  output logic [7:0] cfgByte1,
  output logic [7:0] cfgByte2,
  output logic [7:0] cfgByte3,
  output logic [7:0] cfgByte4,
  output logic [7:0] cfgByte5
);

  cfg_strobe_t strobe;
  logic sdaS, ackLow, txActive, txBit;
  logic [7:0] rxByte;
  logic [NUM_REGS-1:0][7:0] cfgView;

  i2c_cfg_ctrl #(.DEV_ADDR(DEV_ADDR), .SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn), .rxByte(rxByte),
    .sdaS(sdaS), .strobe(strobe), .ackLow(ackLow), .txActive(txActive)
  );

  i2c_cfg_datapath u_data (
    .clk(clk), .rstN(rstN), .strobe(strobe), .sdaS(sdaS), .fsStrap(fsStrap),
    .rxByte(rxByte), .txBit(txBit), .cfgView(cfgView)
  );

  assign sdaDrvLow = ackLow | (txActive & ~txBit);
  assign cfgByte0  = cfgView[0];
  assign cfgByte1  = cfgView[1];
  assign cfgByte2  = cfgView[2];
  assign cfgByte3  = cfgView[3];
  assign cfgByte4  = cfgView[4];
  assign cfgByte5  = cfgView[5];

endmodule

// File: rtl/i2c_cfg_checker.sv
module i2c_cfg_checker (
  input logic       clk,
  input logic       rstN,
  input logic       sclIn,
  input logic       sdaDrvLow,
  input logic [3:0] fsStrap,
  input logic [7:0] cfgByte0,
  input logic [7:0] cfgByte1,
  input logic [7:0] cfgByte4
);

  always @(negedge clk) begin
    if (!rstN) begin
      a_r6_reset_values: assert (cfgByte0 == 8'h00 && cfgByte1[6:0] == 7'h7F);
    end
  end

  a_r11_drive_on_scl_low: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sdaDrvLow) |-> !sclIn);

  a_r11_release_on_scl_low: assert property (@(posedge clk) disable iff (!rstN)
    $fell(sdaDrvLow) |-> !sclIn);

  a_r3_commit_while_scl_high: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(cfgByte0) |-> sclIn);

  a_r8_byte4_fixed: assert property (@(posedge clk) disable iff (!rstN)
    $stable(fsStrap) |-> $stable(cfgByte4));

endmodule

bind i2c_cfg_slave i2c_cfg_checker u_cfgChk (
  .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaDrvLow(sdaDrvLow),
  .fsStrap(fsStrap), .cfgByte0(cfgByte0), .cfgByte1(cfgByte1), .cfgByte4(cfgByte4)
);

// File: tb/i2c_cfg_slave_bench.sv
module i2c_cfg_slave_bench;

  localparam int CLK_PERIOD = 10;
  localparam int Q          = 8;
  localparam int NVEC       = 6;
  // {count, d0, d1, d2, d3, d4, d5, spare}
  localparam logic [63:0] VEC [NVEC] = '{
    64'h06_5A_00_00_00_00_00_00,
    64'h06_A5_FF_FF_FF_FF_FF_00,
    64'h02_3C_00_00_00_00_00_00,
    64'h00_00_00_00_00_00_00_00,
    64'h04_81_0A_55_12_00_00_00,
    64'h01_7E_00_00_00_00_00_00
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclLine = 1'b1;
  logic sdaHostLow = 1'b0;
  logic [3:0] fs = 4'b1010;
  logic sdaDrvLow;
  logic sdaBus;
  logic [7:0] cfgPort [6];
  logic [7:0] mdl [6];
  int nChecks = 0;
  int nFail = 0;

  assign sdaBus = ~(sdaHostLow | sdaDrvLow);
  always #(CLK_PERIOD / 2) clk = ~clk;

  i2c_cfg_slave u_i2c_cfg_slave (
    .clk(clk), .rstN(rstN), .sclIn(sclLine), .sdaIn(sdaBus), .sdaDrvLow(sdaDrvLow),
    .fsStrap(fs), .cfgByte0(cfgPort[0]), .cfgByte1(cfgPort[1]), .cfgByte2(cfgPort[2]),
    .cfgByte3(cfgPort[3]), .cfgByte4(cfgPort[4]), .cfgByte5(cfgPort[5])
  );

  function automatic logic [7:0] wm(int i);
    case (i)
      0: return 8'hFF;
      1: return 8'h0B;
      2: return 8'h5F;
      3: return 8'h37;
      5: return 8'h13;
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic [7:0] expView(int i);
    logic [7:0] fixedBits;
    case (i)
      1: fixedBits = 8'h74 | {~fs[2], 7'b0};
      2: fixedBits = 8'hA0;
      3: fixedBits = 8'h88 | {1'b0, ~fs[0], 6'b0};
      4: fixedBits = 8'hF5 | {4'b0, ~fs[1], 1'b0, ~fs[3], 1'b0};
      5: fixedBits = 8'hEC;
      default: fixedBits = 8'h00;
    endcase
    return (mdl[i] & wm(i)) | fixedBits;
  endfunction

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: got %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic chkAll(string tag);
    for (int i = 0; i < 6; i++) chk(tag, cfgPort[i], expView(i));
  endtask

  task automatic i2cStart();
    sdaHostLow = 1'b0; tick(Q);
    sclLine = 1'b1;    tick(Q);
    sdaHostLow = 1'b1; tick(Q);
    sclLine = 1'b0;    tick(Q);
  endtask

  task automatic i2cStop();
    sdaHostLow = 1'b1; tick(Q);
    sclLine = 1'b1;    tick(Q);
    sdaHostLow = 1'b0; tick(Q);
  endtask

  task automatic sendBits(logic [7:0] b, int nBits);
    for (int i = 7; i > 7 - nBits; i--) begin
      sdaHostLow = ~b[i]; tick(Q);
      sclLine = 1'b1;     tick(2 * Q);
      sclLine = 1'b0;     tick(Q);
    end
  endtask

  task automatic sendByte(logic [7:0] b, output logic acked);
    sendBits(b, 8);
    sdaHostLow = 1'b0; tick(Q);
    sclLine = 1'b1;    tick(Q);
    acked = ~sdaBus;   tick(Q);
    sclLine = 1'b0;    tick(Q);
  endtask

  task automatic recvByte(output logic [7:0] b, input logic giveAck);
    for (int i = 7; i >= 0; i--) begin
      sdaHostLow = 1'b0; tick(Q);
      sclLine = 1'b1;    tick(Q);
      b[i] = sdaBus;     tick(Q);
      sclLine = 1'b0;    tick(Q);
    end
    sdaHostLow = giveAck; tick(Q);
    sclLine = 1'b1;       tick(2 * Q);
    sclLine = 1'b0;       tick(Q);
    sdaHostLow = 1'b0;
  endtask

  task automatic writeHeader(string tag);
    logic a;
    i2cStart();
    sendByte(8'hD2, a); chk({tag, " R1 addr ack"}, {7'b0, a}, 8'h01);
    sendByte(8'hA5, a); chk({tag, " R2 cmd ack"}, {7'b0, a}, 8'h01);
    sendByte(8'h5A, a); chk({tag, " R2 count ack"}, {7'b0, a}, 8'h01);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end

  initial begin
    logic a;
    logic [7:0] rb;
    mdl = '{8'h00, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF};
    tick(4);
    rstN = 1'b1;
    tick(4);

    // R6 reset state, R11 idle bus not driven
    chkAll("R6 reset");
    chk("R11 idle drive", {7'b0, sdaDrvLow}, 8'h00);

    // R3 R7 R8 vector table
    for (int v = 0; v < NVEC; v++) begin
      int n;
      n = int'(VEC[v][63:56]);
      writeHeader("vec");
      for (int k = 0; k < n; k++) begin
        logic [7:0] d;
        d = VEC[v][55 - 8 * k -: 8];
        sendByte(d, a);
        chk("R3 data ack", {7'b0, a}, 8'h01);
        mdl[k] = d;
      end
      i2cStop();
      tick(4);
      chkAll("R3 R7 R8 vector regs");
    end

    // R1 wrong address: no ack, no change
    i2cStart();
    sendByte(8'hD4, a);
    chk("R1 wrong addr nack", {7'b0, a}, 8'h00);
    sendByte(8'h00, a);
    sendByte(8'h00, a);
    sendByte(8'h00, a);
    i2cStop();
    tick(4);
    chkAll("R1 wrong addr regs");

    // R4 partial byte cut by STOP
    writeHeader("R4");
    sendByte(8'hC3, a);
    mdl[0] = 8'hC3;
    sendBits(8'h00, 4);
    i2cStop();
    tick(4);
    chkAll("R4 partial byte");

    // R5 seventh data byte
    writeHeader("R5");
    for (int k = 0; k < 6; k++) begin
      sendByte(8'h11 * (k + 1), a);
      mdl[k] = 8'h11 * (k + 1);
    end
    sendByte(8'h00, a);
    chk("R5 extra byte nack", {7'b0, a}, 8'h00);
    i2cStop();
    tick(4);
    chkAll("R5 extra byte regs");

    // R7 strap change
    fs = 4'b0101;
    tick(2);
    chkAll("R7 strap view");

    // R9 block read
    i2cStart();
    sendByte(8'hD3, a);
    chk("R1 read addr ack", {7'b0, a}, 8'h01);
    recvByte(rb, 1'b1);
    chk("R9 count byte", rb, 8'h06);
    for (int k = 0; k < 6; k++) begin
      recvByte(rb, (k != 5));
      chk("R9 read data", rb, expView(k));
    end
    i2cStop();
    tick(4);

    // R10 host NACK releases SDA
    i2cStart();
    sendByte(8'hD3, a);
    recvByte(rb, 1'b0);
    chk("R10 count before nack", rb, 8'h06);
    recvByte(rb, 1'b0);
    chk("R10 released after nack", rb, 8'hFF);
    i2cStop();
    tick(4);
    chk("R11 idle after stop", {7'b0, sdaDrvLow}, 8'h00);
    chkAll("R2 regs after reads");

    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end

endmodule